// File: doc/BRIEF.md
# Three-Component Tausworthe Uniform Word Generator

This block produces a stream of uniformly distributed pseudo-random 32-bit words, one per clock cycle on which its enable is high. Three independent 32-bit shift-register recurrences of the Tausworthe type run side by side. Each has its own shift amounts and keep-mask, and the published word is the XOR of their three freshly updated states. The three component periods are coprime, so the combined sequence repeats only after about 2^88 words.

Three seed words, one for each component, are captured while the synchronous reset is high, so a reset always restarts the exact same sequence. A seed that is too small for its component, which could leave that component stuck at zero, is raised to a legal value as it is loaded. A Gaussian noise transform that needs two independent uniform inputs uses two instances of this block with different seed triples.

Top module: `tri_taus_urng`

## Requirements
- R1: On a clock edge with `rst_i` high, the three component states load their (fixed-up) seeds, `rnd_o` becomes 0 and `rnd_vld_o` becomes 0.
- R2: On each enabled cycle, component A (seeded from `seed_a_i`) updates as t=((s<<13)^s)>>19, s'=((s & 0xFFFFFFFE)<<12)^t, all in 32-bit unsigned arithmetic.
- R3: On each enabled cycle, component B (seeded from `seed_b_i`) updates as t=((s<<2)^s)>>25, s'=((s & 0xFFFFFFF8)<<4)^t.
- R4: On each enabled cycle, component C (seeded from `seed_c_i`) updates as t=((s<<3)^s)>>11, s'=((s & 0xFFFFFFF0)<<17)^t.
- R5: After an enabled edge with `rst_i` low, `rnd_o` equals the XOR of the three updated component states and `rnd_vld_o` is 1, with no further delay.
- R6: After an edge with `en_i` low and `rst_i` low, `rnd_vld_o` is 0, `rnd_o` keeps its value and no component state advances, so the next enabled word continues the sequence.
- R7: A seed below its component's minimum (2 for A, 8 for B, 16 for C) is loaded as the seed plus that minimum; other seeds load unchanged.
- R8: Asserting reset at any point, with the same seeds, makes the following enabled words repeat the sequence from its first word.
- R9: Seed inputs are sampled only while `rst_i` is high; changing them while `rst_i` is low has no effect on the output sequence.
- R10: No component state is ever zero after reset, so the output sequence never degenerates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, loads the seeds |
| en_i | input | 1 | Advance enable, one word per enabled cycle |
| seed_a_i | input | 32 | Seed for component A |
| seed_b_i | input | 32 | Seed for component B |
| seed_c_i | input | 32 | Seed for component C |
| rnd_o | output | 32 | Uniform output word |
| rnd_vld_o | output | 1 | High for one cycle after each enabled update |

## Verification
The bench builds the block with its default parameters: 32-bit words and the three fixed component shift sets, which are the only set the period argument covers. That brings into reach a word-for-word comparison of a thousand outputs against an independently written recurrence model for two different seed triples, and the too-small seed corners (all-zero seeds and seeds one below each minimum). Enable gaps, a mid-stream reset and seed changes without reset are each driven while the model runs alongside, so a stalled, skipped or restarted word shows up at the output.

// File: rtl/urng_pkg.sv
package urng_pkg;

  localparam int WORD_W   = 32;
  localparam int NUM_COMP = 3;

  // Shift and mask selection for each component index.
  function automatic int comp_shl_a(input int idx);
    case (idx)
      0: return 13;
      1: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int comp_shr_b(input int idx);
    case (idx)
      0: return 19;
      1: return 25;
      default: return 11;
    endcase
  endfunction

  function automatic int comp_shl_c(input int idx);
    case (idx)
      0: return 12;
      1: return 4;
      default: return 17;
    endcase
  endfunction

  // Number of low bits dropped by the keep-mask; the minimum legal seed is 2**drop.
  function automatic int comp_drop(input int idx);
    case (idx)
      0: return 1;
      1: return 3;
      default: return 4;
    endcase
  endfunction

  // One Tausworthe step in 32-bit unsigned arithmetic.
  function automatic logic [WORD_W-1:0] taus_step(
    input logic [WORD_W-1:0] s,
    input int                shl_a,
    input int                shr_b,
    input int                drop,
    input int                shl_c
  );
    logic [WORD_W-1:0] fb;
    logic [WORD_W-1:0] keep;
    fb   = ((s << shl_a) ^ s) >> shr_b;
    keep = {WORD_W{1'b1}} << drop;
    return ((s & keep) << shl_c) ^ fb;
  endfunction

  // Raise a too-small seed into the legal range.
  function automatic logic [WORD_W-1:0] seed_fixup(
    input logic [WORD_W-1:0] s,
    input int                drop
  );
    logic [WORD_W-1:0] floor_v;
    floor_v = {{(WORD_W-1){1'b0}}, 1'b1} << drop;
    return (s < floor_v) ? (s | floor_v) : s;
  endfunction

endpackage

// File: rtl/taus_component.sv
module taus_component
  import urng_pkg::*;
#(
  parameter int SHL_A = 13,
  parameter int SHR_B = 19,
  parameter int DROP  = 1,
  parameter int SHL_C = 12
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              en_i,
  input  logic [WORD_W-1:0] seed_i,
  output logic [WORD_W-1:0] state_o,
  output logic [WORD_W-1:0] next_o
);

  logic [WORD_W-1:0] state_q;

  assign next_o  = taus_step(state_q, SHL_A, SHR_B, DROP, SHL_C);
  assign state_o = state_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= seed_fixup(seed_i, DROP);
    end else if (en_i) begin
      state_q <= next_o;
    end
  end

endmodule

// File: rtl/taus_combiner.sv
module taus_combiner
  import urng_pkg::*;
#(
  parameter int N = NUM_COMP
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              en_i,
  input  logic [WORD_W-1:0] next_i [N],
  output logic [WORD_W-1:0] rnd_o,
  output logic              vld_o
);

  logic [WORD_W-1:0] mix;

  always_comb begin
    mix = '0;
    for (int k = 0; k < N; k++) begin
      mix = mix ^ next_i[k];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rnd_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= en_i;
      if (en_i) begin
        rnd_o <= mix;
      end
    end
  end

endmodule

// File: rtl/tri_taus_urng.sv
module tri_taus_urng
  import urng_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              en_i,
  input  logic [WORD_W-1:0] seed_a_i,
  input  logic [WORD_W-1:0] seed_b_i,
  input  logic [WORD_W-1:0] seed_c_i,
  output logic [WORD_W-1:0] rnd_o,
  output logic              rnd_vld_o
);

  logic [WORD_W-1:0] seed_arr   [NUM_COMP];
  logic [WORD_W-1:0] comp_state [NUM_COMP];
  logic [WORD_W-1:0] comp_next  [NUM_COMP];

  assign seed_arr[0] = seed_a_i;
  assign seed_arr[1] = seed_b_i;
  assign seed_arr[2] = seed_c_i;

  for (genvar g = 0; g < NUM_COMP; g++) begin : g_comp
    taus_component #(
      .SHL_A(comp_shl_a(g)),
      .SHR_B(comp_shr_b(g)),
      .DROP (comp_drop(g)),
      .SHL_C(comp_shl_c(g))
    ) u_comp (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .en_i   (en_i),
      .seed_i (seed_arr[g]),
      .state_o(comp_state[g]),
      .next_o (comp_next[g])
    );
  end

  taus_combiner #(.N(NUM_COMP)) u_mix (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .en_i  (en_i),
    .next_i(comp_next),
    .rnd_o (rnd_o),
    .vld_o (rnd_vld_o)
  );

  // Named taps for the checker.
  logic [WORD_W-1:0] st_a, st_b, st_c;
  assign st_a = comp_state[0];
  assign st_b = comp_state[1];
  assign st_c = comp_state[2];

endmodule

// File: rtl/tri_taus_urng_chk.sv
module tri_taus_urng_chk
  import urng_pkg::*;
(
  input logic              clk_i,
  input logic              rst_i,
  input logic              en_i,
  input logic [WORD_W-1:0] rnd_o,
  input logic              rnd_vld_o,
  input logic [WORD_W-1:0] st_a,
  input logic [WORD_W-1:0] st_b,
  input logic [WORD_W-1:0] st_c
);

  a_r1_reset_clears: assert property (@(posedge clk_i)
    rst_i |=> (!rnd_vld_o && rnd_o == '0));

  a_r5_valid_after_enable: assert property (@(posedge clk_i) disable iff (rst_i)
    en_i |=> rnd_vld_o);

  a_r5_word_is_state_mix: assert property (@(posedge clk_i) disable iff (rst_i)
    rnd_vld_o |-> (rnd_o == (st_a ^ st_b ^ st_c)));

  a_r6_hold_when_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (!rnd_vld_o && $stable(rnd_o) && $stable(st_a) && $stable(st_b) && $stable(st_c)));

  a_r10_no_zero_state: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_a != '0) && (st_b != '0) && (st_c != '0));

endmodule

bind tri_taus_urng tri_taus_urng_chk chk_i (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .en_i     (en_i),
  .rnd_o    (rnd_o),
  .rnd_vld_o(rnd_vld_o),
  .st_a     (st_a),
  .st_b     (st_b),
  .st_c     (st_c)
);

// File: tb/tri_taus_urng_tb_top.sv
`timescale 1ns/1ps
module tri_taus_urng_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_i = 1'b1;
  logic        en_i  = 1'b0;
  logic [31:0] seed_a_i = 32'd0;
  logic [31:0] seed_b_i = 32'd0;
  logic [31:0] seed_c_i = 32'd0;
  logic [31:0] rnd_o;
  logic        rnd_vld_o;

  int n_chk  = 0;
  int n_fail = 0;

  // Reference model state.
  logic [31:0] m1, m2, m3;

  always #2 clk_i = ~clk_i;

  tri_taus_urng dut_i (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i),
    .seed_a_i(seed_a_i), .seed_b_i(seed_b_i), .seed_c_i(seed_c_i),
    .rnd_o(rnd_o), .rnd_vld_o(rnd_vld_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] legal(input logic [31:0] s, input logic [31:0] lo);
    return (s < lo) ? s + lo : s;
  endfunction

  // Model: seeds as loaded under reset.
  task automatic model_load(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    m1 = legal(a, 32'd2);
    m2 = legal(b, 32'd8);
    m3 = legal(c, 32'd16);
  endtask

  // Model: advance all three components, return the combined word.
  task automatic model_next(output logic [31:0] w);
    logic [31:0] t;
    t  = ((m1 << 13) ^ m1) >> 19;  m1 = ((m1 & 32'hFFFF_FFFE) << 12) ^ t;
    t  = ((m2 << 2)  ^ m2) >> 25;  m2 = ((m2 & 32'hFFFF_FFF8) << 4)  ^ t;
    t  = ((m3 << 3)  ^ m3) >> 11;  m3 = ((m3 & 32'hFFFF_FFF0) << 17) ^ t;
    w = m1 ^ m2 ^ m3;
  endtask

  task automatic do_reset(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    @(negedge clk_i);
    rst_i = 1'b1; en_i = 1'b0;
    seed_a_i = a; seed_b_i = b; seed_c_i = c;
    @(posedge clk_i); #1;
    @(negedge clk_i);
    rst_i = 1'b0;
    model_load(a, b, c);
  endtask

  // One enabled cycle, checked against the model.
  task automatic step_check(input string req);
    logic [31:0] w;
    @(negedge clk_i);
    en_i = 1'b1;
    @(posedge clk_i); #1;
    model_next(w);
    check(req, rnd_o, w);
    check(req, {31'd0, rnd_vld_o}, 32'd1);
    @(negedge clk_i);
    en_i = 1'b0;
  endtask

  task automatic t_reset_state;
    do_reset(32'd2846420573, 32'd2846420573, 32'd2846420573);
    check("R1 word after reset", rnd_o, 32'd0);
    check("R1 valid after reset", {31'd0, rnd_vld_o}, 32'd0);
  endtask

  task automatic t_stream(input logic [31:0] s);
    logic [31:0] w;
    do_reset(s, s, s);
    @(negedge clk_i);
    en_i = 1'b1;
    for (int i = 0; i < 1000; i++) begin
      @(posedge clk_i); #1;
      model_next(w);
      check("R2/R3/R4/R5 stream word", rnd_o, w);
    end
    @(negedge clk_i);
    en_i = 1'b0;
  endtask

  task automatic t_enable_gap;
    logic [31:0] held;
    do_reset(32'd912462866, 32'd912462866, 32'd912462866);
    for (int i = 0; i < 5; i++) step_check("R5 pre-gap");
    held = rnd_o;
    for (int i = 0; i < 7; i++) begin
      @(posedge clk_i); #1;
      check("R6 word held", rnd_o, held);
      check("R6 valid low", {31'd0, rnd_vld_o}, 32'd0);
    end
    for (int i = 0; i < 5; i++) step_check("R6 continues after gap");
  endtask

  task automatic t_seed_floor;
    do_reset(32'd0, 32'd0, 32'd0);
    for (int i = 0; i < 20; i++) step_check("R7 zero seeds");
    do_reset(32'd1, 32'd7, 32'd15);
    for (int i = 0; i < 20; i++) step_check("R7 just-below seeds");
    do_reset(32'd2, 32'd8, 32'd16);
    for (int i = 0; i < 20; i++) step_check("R7 minimum seeds");
  endtask

  task automatic t_restart;
    logic [31:0] first [8];
    logic [31:0] w;
    do_reset(32'h1234_5678, 32'h9ABC_DEF0, 32'h0F1E_2D3C);
    for (int i = 0; i < 8; i++) begin
      step_check("R8 first pass");
      first[i] = rnd_o;
    end
    for (int i = 0; i < 13; i++) step_check("R8 run on");
    do_reset(32'h1234_5678, 32'h9ABC_DEF0, 32'h0F1E_2D3C);
    for (int i = 0; i < 8; i++) begin
      step_check("R8 second pass");
      w = rnd_o;
      check("R8 repeat matches first pass", w, first[i]);
    end
  endtask

  task automatic t_seed_ignored;
    do_reset(32'hCAFE_0001, 32'hBEEF_0002, 32'hD00D_0003);
    for (int i = 0; i < 4; i++) step_check("R9 before seed change");
    @(negedge clk_i);
    seed_a_i = 32'h1111_1111; seed_b_i = 32'h2222_2222; seed_c_i = 32'h3333_3333;
    for (int i = 0; i < 10; i++) step_check("R9 seeds changed without reset");
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset_state();
    t_stream(32'd2846420573);
    t_stream(32'd912462866);
    t_enable_gap();
    t_seed_floor();
    t_restart();
    t_seed_ignored();
    repeat (3) @(posedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule